// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Detect and Monitor Select

This block compares two divided clock streams inside a frequency synthesizer: a reference stream and a feedback stream. Both arrive as level signals on the core clock. A rising edge on the reference raises an up request. A rising edge on the feedback raises a down request. When both requests would be active at once, both are cleared together, and that marks the end of one comparison. The block measures how many core cycles each comparison left a request open. It declares lock once a run of consecutive comparisons stays narrower than a programmable window.

A polarity control swaps which pump request answers which stream, so that loop filters of either sign can be used. One output pin is shared between the lock indication and a monitor of the divided inputs. A second select chooses whether that monitor shows the reference or the feedback. A force control deasserts the pump output enable so that the pump can be driven to high impedance. A run input holds the whole comparator quiet in power-saving mode. The pump current-select bit is passed through unchanged to the analog pump.

Top module: `pfd_lock_core`

## Requirements
- R1: While rst_n is low, pump_up, pump_dn and lock_det are 0.
- R2: With pol_inv=0, a rising edge of ref_in raises pump_up in the following cycle. pump_up stays high until the cycle after the rising edge of fb_in that clears it. A rising edge of fb_in that comes first raises pump_dn in the same way.
- R3: pump_up and pump_dn are never both high.
- R4: With pol_inv=1, the two pump requests are swapped: a leading ref_in edge drives pump_dn and a leading fb_in edge drives pump_up.
- R5: The width of a comparison is the number of core cycles from the leading rising edge to the trailing one, and coincident edges give 0. A comparison is narrow when its width is less than lock_window. lock_q rises in the cycle after the 8th consecutive narrow comparison completes, and stays high while further comparisons remain narrow.
- R6: A completed comparison whose width is at least lock_window clears lock_det and restarts the count of narrow comparisons.
- R7: With mon_sel=1, mon_out equals ref_in when mon_src=0 and fb_in when mon_src=1. With mon_sel=0, mon_out equals lock_det.
- R8: pump_oe equals hiz_n: 0 asks for a high-impedance pump and 1 for normal drive.
- R9: While run=0, pump_up, pump_dn and lock_det are 0 at once. The flags, the width counter and the narrow count are cleared, so after run returns to 1 lock needs 8 new narrow comparisons. If run falls in the same cycle as a comparison completes, that comparison is discarded.
- R10: cs_out equals cur_sel at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = normal operation, 0 = power-saving mode |
| ref_in | input | 1 | Divided reference stream (level) |
| fb_in | input | 1 | Divided feedback stream (level) |
| pol_inv | input | 1 | 1 swaps the up and down requests |
| mon_sel | input | 1 | 1 = monitor on mon_out, 0 = lock indication |
| mon_src | input | 1 | Monitor source: 0 = reference, 1 = feedback |
| hiz_n | input | 1 | 0 forces the pump to high impedance |
| cur_sel | input | 1 | Pump current select, passed through |
| lock_window | input | WIN_W | Narrow-pulse threshold in core cycles |
| pump_up | output | 1 | Pump up request |
| pump_dn | output | 1 | Pump down request |
| pump_oe | output | 1 | Pump output enable |
| cs_out | output | 1 | Current select passed to the pump |
| lock_det | output | 1 | 1 when locked |
| mon_out | output | 1 | Shared lock or monitor output |

## Verification
Two events can fall in the same cycle: a comparison can complete just as the run input drops into power-saving mode. The bench provokes this once the comparator holds lock. It raises the trailing feedback edge and lowers run on the same clock phase. The result is judged at the ports. lock_det and both pump requests must read 0 on the next sample. After run returns, one further narrow comparison must still leave lock_det low, which shows that the completed comparison was discarded and the narrow count restarted.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic {
    MON_LOCK = 1'b0,
    MON_DIV  = 1'b1
  } mon_mode_e;

  // Returns {up, dn} after the polarity control.
  function automatic logic [1:0] apply_polarity(input logic inv,
                                                input logic up,
                                                input logic dn);
    return inv ? {dn, up} : {up, dn};
  endfunction

  function automatic logic pick_source(input logic src,
                                       input logic a,
                                       input logic b);
    return src ? b : a;
  endfunction

endpackage

// File: rtl/pfd_edge_flags.sv
module pfd_edge_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ref_in,
  input  logic fb_in,
  output logic up_q,
  output logic dn_q,
  output logic ref_rise,
  output logic fb_rise,
  output logic cmp_done,
  output logic busy
);
  logic ref_d, fb_d;
  logic up_set, dn_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d <= 1'b0;
      fb_d  <= 1'b0;
    end else begin
      ref_d <= ref_in;
      fb_d  <= fb_in;
    end
  end

  assign ref_rise = ref_in & ~ref_d;
  assign fb_rise  = fb_in & ~fb_d;
  assign up_set   = up_q | ref_rise;
  assign dn_set   = dn_q | fb_rise;
  assign cmp_done = run & up_set & dn_set;
  assign busy     = up_q | dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (!run || cmp_done) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_set;
      dn_q <= dn_set;
    end
  end

  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  p_up_from_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(ref_rise));

  p_dn_from_fb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_q) |-> $past(fb_rise));

  p_save_clears_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!up_q && !dn_q));

endmodule

// File: rtl/pfd_lock_meter.sv
module pfd_lock_meter #(
  parameter int WIN_W      = 8,
  parameter int LOCK_COUNT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cmp_done,
  input  logic             busy,
  input  logic [WIN_W-1:0] window,
  output logic             lock_q,
  output logic             narrow
);
  localparam int CW = $clog2(LOCK_COUNT + 1);
  localparam logic [CW-1:0] LOCK_AT = CW'(LOCK_COUNT);
  localparam logic [WIN_W-1:0] WIDTH_MAX = {WIN_W{1'b1}};

  logic [WIN_W-1:0] wcnt;
  logic [WIN_W-1:0] width;
  logic [CW-1:0]    gcnt;
  logic [CW-1:0]    gcnt_step;

  function automatic logic [WIN_W-1:0] width_inc(input logic [WIN_W-1:0] v);
    return (v == WIDTH_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [CW-1:0] good_inc(input logic [CW-1:0] v);
    return (v >= LOCK_AT) ? LOCK_AT : v + 1'b1;
  endfunction

  // The cycle in which the trailing edge lands still counts toward the width.
  assign width     = busy ? width_inc(wcnt) : wcnt;
  assign narrow    = width < window;
  assign gcnt_step = good_inc(gcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt   <= '0;
      gcnt   <= '0;
      lock_q <= 1'b0;
    end else if (!run) begin
      wcnt   <= '0;
      gcnt   <= '0;
      lock_q <= 1'b0;
    end else if (cmp_done) begin
      wcnt <= '0;
      if (narrow) begin
        gcnt   <= gcnt_step;
        lock_q <= (gcnt_step == LOCK_AT);
      end else begin
        gcnt   <= '0;
        lock_q <= 1'b0;
      end
    end else if (busy) begin
      wcnt <= width_inc(wcnt);
    end
  end

  p_lock_needs_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(cmp_done && narrow));

  p_wide_drops_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmp_done && !narrow) |=> !lock_q);

  p_save_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !lock_q);

endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
  import pfd_pkg::*;
(
  input  logic run,
  input  logic pol_inv,
  input  logic mon_sel,
  input  logic mon_src,
  input  logic hiz_n,
  input  logic cur_sel,
  input  logic up_q,
  input  logic dn_q,
  input  logic lock_q,
  input  logic ref_in,
  input  logic fb_in,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_oe,
  output logic cs_out,
  output logic lock_det,
  output logic mon_out
);
  logic [1:0] oriented;
  mon_mode_e  mode;

  assign oriented = apply_polarity(pol_inv, up_q, dn_q);
  assign pump_up  = run & oriented[1];
  assign pump_dn  = run & oriented[0];
  assign pump_oe  = hiz_n;
  assign cs_out   = cur_sel;
  assign lock_det = run & lock_q;
  assign mode     = mon_mode_e'(mon_sel);

  always_comb begin
    unique case (mode)
      MON_DIV:  mon_out = pick_source(mon_src, ref_in, fb_in);
      default:  mon_out = lock_det;
    endcase
  end

endmodule

// File: rtl/pfd_lock_core.sv
module pfd_lock_core #(
  parameter int WIN_W      = 8,
  parameter int LOCK_COUNT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic             pol_inv,
  input  logic             mon_sel,
  input  logic             mon_src,
  input  logic             hiz_n,
  input  logic             cur_sel,
  input  logic [WIN_W-1:0] lock_window,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             pump_oe,
  output logic             cs_out,
  output logic             lock_det,
  output logic             mon_out
);
  logic up_q, dn_q, ref_rise, fb_rise, cmp_done, busy;
  logic lock_q, narrow;

  pfd_edge_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .ref_in   (ref_in),
    .fb_in    (fb_in),
    .up_q     (up_q),
    .dn_q     (dn_q),
    .ref_rise (ref_rise),
    .fb_rise  (fb_rise),
    .cmp_done (cmp_done),
    .busy     (busy)
  );

  pfd_lock_meter #(
    .WIN_W      (WIN_W),
    .LOCK_COUNT (LOCK_COUNT)
  ) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cmp_done (cmp_done),
    .busy     (busy),
    .window   (lock_window),
    .lock_q   (lock_q),
    .narrow   (narrow)
  );

  pfd_out_stage u_out (
    .run      (run),
    .pol_inv  (pol_inv),
    .mon_sel  (mon_sel),
    .mon_src  (mon_src),
    .hiz_n    (hiz_n),
    .cur_sel  (cur_sel),
    .up_q     (up_q),
    .dn_q     (dn_q),
    .lock_q   (lock_q),
    .ref_in   (ref_in),
    .fb_in    (fb_in),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .pump_oe  (pump_oe),
    .cs_out   (cs_out),
    .lock_det (lock_det),
    .mon_out  (mon_out)
  );

  p_pumps_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!pump_up && !pump_dn && !lock_det));

endmodule

// File: tb/pfd_lock_core_test.sv
module pfd_lock_core_test;
  localparam int WIN_W = 8;
  localparam int NVEC  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b1;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic pol_inv = 1'b0, mon_sel = 1'b0, mon_src = 1'b0;
  logic hiz_n = 1'b1, cur_sel = 1'b0;
  logic [WIN_W-1:0] lock_window = 8'd4;
  logic pump_up, pump_dn, pump_oe, cs_out, lock_det, mon_out;

  int checks = 0;
  int fails = 0;
  int good_run = 0;
  bit done = 1'b0;

  // Vector: [9] reference leads, [8] polarity, [7:0] gap in cycles.
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'd2}, {1'b0, 1'b0, 8'd1}, {1'b1, 1'b1, 8'd3},
    {1'b1, 1'b0, 8'd0}, {1'b0, 1'b1, 8'd2}, {1'b1, 1'b0, 8'd1},
    {1'b0, 1'b0, 8'd3}, {1'b1, 1'b1, 8'd2}, {1'b0, 1'b0, 8'd1},
    {1'b1, 1'b0, 8'd6}, {1'b0, 1'b0, 8'd2}, {1'b1, 1'b1, 8'd1}
  };

  always #4 clk = ~clk;

  pfd_lock_core #(.WIN_W(WIN_W), .LOCK_COUNT(8)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .ref_in(ref_in), .fb_in(fb_in),
    .pol_inv(pol_inv), .mon_sel(mon_sel), .mon_src(mon_src), .hiz_n(hiz_n),
    .cur_sel(cur_sel), .lock_window(lock_window), .pump_up(pump_up),
    .pump_dn(pump_dn), .pump_oe(pump_oe), .cs_out(cs_out),
    .lock_det(lock_det), .mon_out(mon_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // One comparison: the leader rises, the follower rises gap cycles later.
  task automatic compare(input logic ref_first, input logic pol, input int gap);
    logic up_exp;
    pol_inv = pol;
    up_exp = ref_first ^ pol;
    @(negedge clk);
    if (gap == 0) begin
      ref_in = 1'b1; fb_in = 1'b1;
    end else begin
      if (ref_first) ref_in = 1'b1; else fb_in = 1'b1;
      @(negedge clk);
      chk(pol ? "R4 up" : "R2 up", pump_up, up_exp);
      chk(pol ? "R4 dn" : "R2 dn", pump_dn, ~up_exp);
      repeat (gap - 1) @(negedge clk);
      if (ref_first) fb_in = 1'b1; else ref_in = 1'b1;
    end
    @(negedge clk);
    chk("R2 cleared up", pump_up, 1'b0);
    chk("R2 cleared dn", pump_dn, 1'b0);
    if (gap < int'(lock_window)) good_run++; else good_run = 0;
    chk(gap < int'(lock_window) ? "R5 lock" : "R6 lock", lock_det, good_run >= 8);
    chk("R7 lock on mon_out", mon_out, lock_det);
    ref_in = 1'b0; fb_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (all requirements)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 up", pump_up, 1'b0);
    chk("R1 dn", pump_dn, 1'b0);
    chk("R1 lock", lock_det, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++)
      compare(VEC[i][9], VEC[i][8], int'(VEC[i][7:0]));

    // Boundary: width equal to the window is wide (R6), one below is narrow (R5).
    for (int i = 0; i < 8; i++) compare(i[0], 1'b0, 3);
    chk("R5 locked after 8 narrow", lock_det, 1'b1);
    compare(1'b1, 1'b0, 4);
    chk("R6 width equals window drops lock", lock_det, 1'b0);

    // Relock, then power-save falls together with a completing comparison.
    for (int i = 0; i < 8; i++) compare(1'b1, 1'b0, 1);
    chk("R5 relocked", lock_det, 1'b1);
    @(negedge clk);
    ref_in = 1'b1;
    @(negedge clk);
    chk("R2 up before save", pump_up, 1'b1);
    fb_in = 1'b1; run = 1'b0;
    #1;
    chk("R9 pump_up immediate", pump_up, 1'b0);
    chk("R9 lock immediate", lock_det, 1'b0);
    @(negedge clk);
    chk("R9 lock in save", lock_det, 1'b0);
    chk("R9 dn in save", pump_dn, 1'b0);
    ref_in = 1'b0; fb_in = 1'b0;
    @(negedge clk);
    run = 1'b1;
    good_run = 0;
    repeat (2) @(negedge clk);
    compare(1'b1, 1'b0, 1);
    chk("R9 count restarted", lock_det, 1'b0);

    // Pass-through and pump enable.
    hiz_n = 1'b0; cur_sel = 1'b1; #1;
    chk("R8 oe low", pump_oe, 1'b0);
    chk("R10 cs high", cs_out, 1'b1);
    hiz_n = 1'b1; cur_sel = 1'b0; #1;
    chk("R8 oe high", pump_oe, 1'b1);
    chk("R10 cs low", cs_out, 1'b0);

    // Monitor multiplex.
    @(negedge clk);
    mon_sel = 1'b1; mon_src = 1'b0; ref_in = 1'b1; fb_in = 1'b0; #1;
    chk("R7 mon ref", mon_out, 1'b1);
    mon_src = 1'b1; #1;
    chk("R7 mon fb", mon_out, 1'b0);
    fb_in = 1'b1; #1;
    chk("R7 mon fb high", mon_out, 1'b1);
    mon_src = 1'b0; ref_in = 1'b0; #1;
    chk("R7 mon ref low", mon_out, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule